// File: doc/BRIEF.md
# UV-Erasable Byte-Wide PROM Model

This block is a synthesizable, clock-based model of a byte-wide, ultraviolet-erasable programmable read-only memory. It is meant to stand in for such a part inside a larger chip simulation or an emulation fabric. The analog conditions of the real part become two logic flags. `hv_prog` means the programming voltage is present on the output-enable pin. `hv_ident` means the identification voltage is present on address bit 9. Timing delays, supply levels and the physical erase process are not modelled.

From the chip-select, output-enable and `hv_prog` inputs the block decodes one of five modes: standby, output disable, read, program or program inhibit. Program verify is the read mode used right after a program pulse. In read mode it returns the addressed byte, or an identification code when `hv_ident` is set. In program mode it ANDs the input byte into the addressed location, so bits can only go from 1 to 0. A one-cycle `wipe` strobe starts a sweep that sets every location back to all ones. The sweep takes one clock per location, and `wipe_busy` is high while it runs. The array depth is a parameter, and the address is reduced modulo that depth.

The data bus is split into `bus_in`, `bus_out` and `bus_drive` for a pad or a tri-state wrapper outside the block. All control pins are plain levels sampled on the rising clock edge, and all outputs are registered.

Top module: `uvprom_model`

## Requirements
- R1: After reset, `bus_drive` and `wipe_busy` are 0, and every location reads 8'hFF.
- R2: With chip_sel_n=0, out_en_n=0, hv_prog=0, hv_ident=0 and no sweep running (read mode), the block drives from the next cycle: bus_drive=1 and bus_out holds the byte stored at the sampled address.
- R3: With chip_sel_n=1 and hv_prog=0 (standby), bus_drive is 0 in the next cycle, whatever out_en_n is, and bus_out is 8'h00.
- R4: With chip_sel_n=0, out_en_n=1 and hv_prog=0 (output disable), bus_drive is 0 in the next cycle, and the stored contents are unchanged.
- R5: In the first cycle in which chip_sel_n=0 and hv_prog=1 are sampled together after a cycle in which they were not (program pulse), the addressed location becomes old AND bus_in. While hv_prog=1, bus_drive is 0 from the next cycle.
- R6: A program pulse held over several cycles writes only once, in its first cycle; later changes of bus_in during the same pulse have no effect.
- R7: With chip_sel_n=1 and hv_prog=1 (program inhibit), no location is written and bus_drive is 0.
- R8: Programming never turns a 0 bit into a 1; only the sweep does.
- R9: In read mode with hv_ident=1, bus_out is 8'h8F when address bit 0 is 0 and 8'h85 when it is 1. The other address bits are ignored.
- R10: A wipe strobe sampled while no sweep runs raises wipe_busy in the next cycle. wipe_busy stays high for exactly DEPTH cycles, after which every location reads 8'hFF.
- R11: While wipe_busy is 1, bus_drive is 0, and wipe strobes and program pulses are ignored.
- R12: The location used is the address modulo DEPTH, so addresses a and a+DEPTH reach the same byte.
- R13: Program verify: dropping hv_prog with chip_sel_n and out_en_n low, right after a program pulse, reads back the programmed byte in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; fills the array with ones |
| addr | input | ADDR_W | Byte address, reduced modulo DEPTH |
| chip_sel_n | input | 1 | Chip select / program strobe, active low |
| out_en_n | input | 1 | Output enable, active low |
| hv_prog | input | 1 | Programming voltage present on the output-enable pin |
| hv_ident | input | 1 | Identification voltage present on address bit 9 |
| bus_in | input | 8 | Byte to program |
| bus_out | output | 8 | Byte read out; 0 when not driving |
| bus_drive | output | 1 | High when the data bus is driven |
| wipe | input | 1 | One-cycle erase request |
| wipe_busy | output | 1 | High while the erase sweep runs |

## Verification
A wrong mode decode or output register shows at the ports one cycle after the control inputs change, as `bus_drive` high in a floating mode, or as a wrong byte or identification code. A wrong edge register in the program path does not show until the location is read back. It then appears as a missing AND or as a second AND of a later `bus_in` value, so every program scenario ends with a read of the location. A wrong sweep counter shows as a `wipe_busy` pulse of the wrong length, or as leftover zero bits at the end of the sweep. The bench therefore counts the busy cycles and reads the programmed locations afterwards.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MAKER_ID = 8'h8F;
  localparam logic [BYTE_W-1:0] PART_ID  = 8'h85;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_PROGRAM,
    MODE_INHIBIT
  } prom_mode_e;
endpackage

// File: rtl/uvprom_ctrl.sv
// Mode decode and single-shot program pulse detection.
module uvprom_ctrl
  import uvprom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_sel_n,
  input  logic       out_en_n,
  input  logic       hv_prog,
  input  logic       busy,
  output prom_mode_e mode,
  output logic       pg_fire
);
  logic strobe;
  logic strobe_q;

  // The raised voltage on the output-enable pin overrides its logic level.
  always_comb begin
    if (hv_prog)         mode = chip_sel_n ? MODE_INHIBIT : MODE_PROGRAM;
    else if (chip_sel_n) mode = MODE_STANDBY;
    else if (out_en_n)   mode = MODE_DISABLE;
    else                 mode = MODE_READ;
  end

  assign strobe = (mode == MODE_PROGRAM);

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  // One write per pulse; a pulse starting during a sweep is consumed.
  assign pg_fire = strobe & ~strobe_q & ~busy;
endmodule

// File: rtl/uvprom_wipe_seq.sv
// Erase sweep: one location per clock, DEPTH clocks in total.
module uvprom_wipe_seq #(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  output logic             busy,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (wipe) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST_IDX) busy <= 1'b0;
    end
  end

  assign clr_en  = busy;
  assign clr_idx = cnt;
endmodule

// File: rtl/uvprom_array.sv
// Storage with one-way (AND) programming and a clear port.
module uvprom_array
  import uvprom_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              pg_en,
  input  logic [IDX_W-1:0]  pg_idx,
  input  logic [BYTE_W-1:0] pg_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx
);
  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (clr_en) begin
      cells[clr_idx] <= '1;
    end else if (pg_en) begin
      cells[pg_idx] <= cells[pg_idx] & pg_data;
    end
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/uvprom_out_stage.sv
// Registered output: array byte or identification code, or float.
module uvprom_out_stage
  import uvprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  prom_mode_e        mode,
  input  logic              busy,
  input  logic              hv_ident,
  input  logic              sel_lsb,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_drive
);
  logic              drive_d;
  logic [BYTE_W-1:0] byte_d;

  always_comb begin
    drive_d = (mode == MODE_READ) && !busy;
    if (!drive_d)      byte_d = '0;
    else if (hv_ident) byte_d = sel_lsb ? PART_ID : MAKER_ID;
    else               byte_d = rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_drive <= 1'b0;
      bus_out   <= '0;
    end else begin
      bus_drive <= drive_d;
      bus_out   <= byte_d;
    end
  end
endmodule

// File: rtl/uvprom_model.sv
module uvprom_model
  import uvprom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              hv_prog,
  input  logic              hv_ident,
  input  logic [BYTE_W-1:0] bus_in,
  output logic [BYTE_W-1:0] bus_out,
  output logic              bus_drive,
  input  logic              wipe,
  output logic              wipe_busy
);
  localparam int  IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit  DEPTH_P2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [IDX_W-1:0]  idx;
  prom_mode_e        mode;
  logic              pg_fire;
  logic              clr_en;
  logic [IDX_W-1:0]  clr_idx;
  logic [BYTE_W-1:0] rd_data;

  // Address folding: a bit slice for power-of-two depths, a modulo otherwise.
  generate
    if (DEPTH_P2 && (ADDR_W > IDX_W)) begin : g_slice
      logic addr_hi_unused;
      assign idx            = addr[IDX_W-1:0];
      assign addr_hi_unused = ^addr[ADDR_W-1:IDX_W];
    end else begin : g_mod
      assign idx = IDX_W'(addr % DEPTH);
    end
  endgenerate

  uvprom_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel_n (chip_sel_n),
    .out_en_n   (out_en_n),
    .hv_prog    (hv_prog),
    .busy       (wipe_busy),
    .mode       (mode),
    .pg_fire    (pg_fire)
  );

  uvprom_wipe_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (wipe),
    .busy    (wipe_busy),
    .clr_en  (clr_en),
    .clr_idx (clr_idx)
  );

  uvprom_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (idx),
    .rd_data (rd_data),
    .pg_en   (pg_fire),
    .pg_idx  (idx),
    .pg_data (bus_in),
    .clr_en  (clr_en),
    .clr_idx (clr_idx)
  );

  uvprom_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .busy      (wipe_busy),
    .hv_ident  (hv_ident),
    .sel_lsb   (addr[0]),
    .rd_data   (rd_data),
    .bus_out   (bus_out),
    .bus_drive (bus_drive)
  );
endmodule

// File: rtl/uvprom_model_chk.sv
module uvprom_model_chk
  import uvprom_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_lsb,
  input logic              chip_sel_n,
  input logic              out_en_n,
  input logic              hv_prog,
  input logic              hv_ident,
  input logic [BYTE_W-1:0] bus_out,
  input logic              bus_drive,
  input logic              wipe,
  input logic              wipe_busy
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !wipe_busy) busy_run <= 0;
    else                      busy_run <= busy_run + 1;
  end

  p_drive_only_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> $past(!chip_sel_n && !out_en_n && !hv_prog && !wipe_busy));

  p_standby_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel_n && !hv_prog) |=> (!bus_drive && bus_out == '0));

  p_disable_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n && out_en_n && !hv_prog) |=> !bus_drive);

  // Covers program (R5) and program inhibit (R7).
  p_hv_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hv_prog |=> !bus_drive);

  p_maker_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n && !out_en_n && !hv_prog && hv_ident && !wipe_busy && !addr_lsb)
      |=> (bus_drive && bus_out == MAKER_ID));

  p_part_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n && !out_en_n && !hv_prog && hv_ident && !wipe_busy && addr_lsb)
      |=> (bus_drive && bus_out == PART_ID));

  p_wipe_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe && !wipe_busy) |=> wipe_busy);

  p_wipe_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_busy |-> (busy_run < DEPTH));

  p_busy_mute_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_busy |=> !bus_drive);
endmodule

bind uvprom_model uvprom_model_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_lsb   (addr[0]),
  .chip_sel_n (chip_sel_n),
  .out_en_n   (out_en_n),
  .hv_prog    (hv_prog),
  .hv_ident   (hv_ident),
  .bus_out    (bus_out),
  .bus_drive  (bus_drive),
  .wipe       (wipe),
  .wipe_busy  (wipe_busy)
);

// File: tb/uvprom_model_test.sv
`timescale 1ns/1ps
module uvprom_model_test;
  localparam int ADDR_W = 16;
  localparam int DEPTH  = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              chip_sel_n, out_en_n, hv_prog, hv_ident, wipe;
  logic [7:0]        bus_in;
  logic [7:0]        bus_out;
  logic              bus_drive, wipe_busy;

  logic [7:0] ref_mem [DEPTH];
  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  uvprom_model #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .chip_sel_n(chip_sel_n),
    .out_en_n(out_en_n), .hv_prog(hv_prog), .hv_ident(hv_ident),
    .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive),
    .wipe(wipe), .wipe_busy(wipe_busy)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  task automatic idle();
    chip_sel_n = 1'b1; out_en_n = 1'b1; hv_prog = 1'b0; hv_ident = 1'b0; wipe = 1'b0;
  endtask

  task automatic read_chk(input int a, input logic [7:0] exp, input string tag);
    chip_sel_n = 1'b0; out_en_n = 1'b0; hv_prog = 1'b0; hv_ident = 1'b0;
    addr = ADDR_W'(a);
    tick();
    check(bus_drive && bus_out == exp, tag, {bus_drive, bus_out}, {1'b1, exp});
  endtask

  task automatic prog_byte(input int a, input logic [7:0] d, input string tag);
    idle(); tick();
    addr = ADDR_W'(a); bus_in = d; hv_prog = 1'b1; chip_sel_n = 1'b0;
    tick();
    check(!bus_drive, tag, bus_drive, 0);
    chip_sel_n = 1'b1; tick();
    hv_prog = 1'b0;
    ref_mem[a % DEPTH] = ref_mem[a % DEPTH] & d;
  endtask

  task automatic t_reset();
    check(!bus_drive && !wipe_busy, "R1 reset outputs", {bus_drive, wipe_busy}, 0);
    read_chk(0, 8'hFF, "R1 erased loc 0");
    read_chk(DEPTH - 1, 8'hFF, "R1 erased last loc");
  endtask

  task automatic t_program_read();
    prog_byte(5, 8'hA5, "R5 float in program");
    read_chk(5, ref_mem[5], "R2 R5 read programmed byte");
    read_chk(3, ref_mem[3], "R2 untouched byte");
  endtask

  task automatic t_one_way();
    prog_byte(5, 8'hFF, "R8 float");
    read_chk(5, ref_mem[5], "R8 ones do not restore");
    prog_byte(5, 8'h0F, "R8 float");
    read_chk(5, 8'h05, "R8 AND of old and new");
  endtask

  task automatic t_one_shot();
    idle(); tick();
    addr = 9; bus_in = 8'hF0; hv_prog = 1'b1; chip_sel_n = 1'b0;
    tick();
    bus_in = 8'h00;
    tick(); tick();
    idle(); tick();
    ref_mem[9] = ref_mem[9] & 8'hF0;
    read_chk(9, 8'hF0, "R6 held pulse writes once");
  endtask

  task automatic t_verify();
    idle(); tick();
    addr = 11; bus_in = 8'h5A; hv_prog = 1'b1; chip_sel_n = 1'b0;
    tick();
    hv_prog = 1'b0; out_en_n = 1'b0;
    tick();
    ref_mem[11] = ref_mem[11] & 8'h5A;
    check(bus_drive && bus_out == 8'h5A, "R13 program verify", bus_out, 8'h5A);
  endtask

  task automatic t_inhibit();
    idle(); tick();
    addr = 3; bus_in = 8'h00; hv_prog = 1'b1; chip_sel_n = 1'b1;
    tick(); tick();
    check(!bus_drive, "R7 inhibit float", bus_drive, 0);
    read_chk(3, 8'hFF, "R7 inhibit no write");
  endtask

  task automatic t_standby_disable();
    idle(); out_en_n = 1'b0; addr = 5; tick();
    check(!bus_drive && bus_out == 8'h00, "R3 standby oe low", bus_drive, 0);
    out_en_n = 1'b1; tick();
    check(!bus_drive, "R3 standby oe high", bus_drive, 0);
    chip_sel_n = 1'b0; out_en_n = 1'b1; tick();
    check(!bus_drive, "R4 output disable float", bus_drive, 0);
    read_chk(5, ref_mem[5], "R4 contents kept");
  endtask

  task automatic t_ident();
    chip_sel_n = 1'b0; out_en_n = 1'b0; hv_prog = 1'b0; hv_ident = 1'b1;
    addr = 0; tick();
    check(bus_drive && bus_out == 8'h8F, "R9 maker code", bus_out, 8'h8F);
    addr = 1; tick();
    check(bus_drive && bus_out == 8'h85, "R9 part code", bus_out, 8'h85);
    addr = 16'h0204; tick();
    check(bus_drive && bus_out == 8'h8F, "R9 upper bits ignored", bus_out, 8'h8F);
    read_chk(5, ref_mem[5], "R9 normal read after ident");
  endtask

  task automatic t_modulo();
    prog_byte(DEPTH + 7, 8'h3C, "R12 float");
    read_chk(7, 8'h3C, "R12 folded write");
    read_chk(2 * DEPTH + 7, 8'h3C, "R12 folded read");
  endtask

  task automatic t_wipe();
    int busy_cnt = 0;
    idle(); wipe = 1'b1; tick(); wipe = 1'b0;
    check(wipe_busy, "R10 busy rises", wipe_busy, 1);
    if (wipe_busy) busy_cnt++;
    chip_sel_n = 1'b0; out_en_n = 1'b0; addr = 7; tick();
    check(!bus_drive, "R11 no drive during sweep", bus_drive, 0);
    if (wipe_busy) busy_cnt++;
    chip_sel_n = 1'b1; out_en_n = 1'b1; hv_prog = 1'b1; tick();
    if (wipe_busy) busy_cnt++;
    chip_sel_n = 1'b0; bus_in = 8'h00; addr = 9; tick();
    if (wipe_busy) busy_cnt++;
    idle(); wipe = 1'b1; tick(); wipe = 1'b0;
    if (wipe_busy) busy_cnt++;
    for (int i = 0; i < 4 * DEPTH && wipe_busy; i++) begin
      tick();
      if (wipe_busy) busy_cnt++;
    end
    check(busy_cnt == DEPTH, "R10 R11 busy length", busy_cnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    read_chk(5, 8'hFF, "R10 location cleared");
    read_chk(7, 8'hFF, "R10 folded location cleared");
    read_chk(9, 8'hFF, "R11 program during sweep ignored");
    read_chk(11, 8'hFF, "R10 verify location cleared");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    rst_n = 1'b0; addr = '0; bus_in = '0;
    idle();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_program_read();
    t_one_way();
    t_one_shot();
    t_verify();
    t_inhibit();
    t_standby_disable();
    t_ident();
    t_modulo();
    t_wipe();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end
endmodule